// File: doc/BRIEF.md
# UART Transmit/Receive Queue Pair with Level Interrupts

This block holds the two data queues that sit between a UART's host interface and its serial shifters. The transmit queue takes 8-bit bytes from the host and hands them one by one to the transmit shifter. The receive queue stores 12-bit entries from the receive shifter and presents them to the host. Each entry is a received byte with four error flags attached. Each side reports empty and full. The receive side also keeps a sticky overrun bit, which records a byte lost because the queue was full.

A single mode input selects the depth of both queues. When it is low, each side is a one-entry holding register. When it is high, each side is a 16-entry FIFO. Any change of the mode input empties both queues. Each direction has its own 3-bit trigger-level register. A load strobe writes both registers, and both come out of reset at half depth. The receive interrupt asserts while the receive queue holds at least the selected number of entries. The transmit interrupt asserts while the transmit queue holds no more than the selected number of entries.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset both queues are empty and not full, `tx_irq` is 1, `rx_irq` is 0, `rx_ovr` is 0, and both trigger levels hold code 2 (half depth).
- R2: While `fifo_en` is 0, each queue holds one entry. One accepted write makes it full, and a transmit write to a full queue is discarded.
- R3: While `fifo_en` is 1, each queue holds DEPTH (16) entries. Entries are returned in write order, and `*_full` asserts exactly at DEPTH entries.
- R4: A receive entry is read as `rx_rdata[7:0]` = data byte and `rx_rdata[11:8]` = the four error flags written with it.
- R5: Level codes 0,1,2,3,4 select thresholds of DEPTH/8, DEPTH/4, DEPTH/2, 3·DEPTH/4 and 7·DEPTH/8 (2, 4, 8, 12, 14). Codes 5–7 act as code 2. `lvl_load` = 1 captures `tx_lvl_sel` and `rx_lvl_sel`.
- R6: In FIFO mode `rx_irq` is 1 exactly while the receive count is at or above its threshold. In holding mode it is 1 while the holding register is occupied.
- R7: In FIFO mode `tx_irq` is 1 exactly while the transmit count is at or below its threshold. In holding mode it is 1 while the holding register is empty.
- R8: A receive write to a full queue with no read in the same cycle is discarded, the stored entries are unchanged, and `rx_ovr` sets. `rx_ovr` stays set until a cycle with `ovr_clr` = 1 and no new overrun. If a new overrun and the clear happen in the same cycle, the set wins.
- R9: A change of `fifo_en` in either direction empties both queues on the next cycle. Writes made in that cycle are dropped.
- R10: A write and a read in the same cycle on a full queue are both accepted: the head leaves, the new entry joins the tail, and the queue stays full.
- R11: A read of an empty queue has no effect. The queue stays empty, and the next written entry is the next one returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = 16-entry FIFO mode, 0 = one-entry holding mode |
| lvl_load | input | 1 | Captures both trigger-level selects |
| tx_lvl_sel | input | 3 | Transmit trigger-level code |
| rx_lvl_sel | input | 3 | Receive trigger-level code |
| tx_wr | input | 1 | Host writes a transmit byte |
| tx_wdata | input | 8 | Transmit byte |
| tx_rd | input | 1 | Transmit shifter takes the head byte |
| tx_rdata | output | 8 | Head byte of the transmit queue |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_irq | output | 1 | Transmit level interrupt |
| rx_wr | input | 1 | Receive shifter delivers an entry |
| rx_wdata | input | 8 | Received byte |
| rx_werr | input | 4 | Error flags for the received byte |
| rx_rd | input | 1 | Host reads the head entry |
| rx_rdata | output | 12 | Head entry: flags in [11:8], data in [7:0] |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_irq | output | 1 | Receive level interrupt |
| ovr_clr | input | 1 | Clears the overrun bit |
| rx_ovr | output | 1 | Sticky receive overrun |

## Verification
Two pairs of events can land in the same cycle. A receive push and a host pop can meet on a full queue, and an overrun can coincide with a clear of the overrun bit. The bench drives `rx_wr` and `rx_rd` together while the queue holds 16 entries. It then requires `rx_full` to stay high and requires the scoreboard to see the old head leave and the new entry come out last, in order. For the second pair, it pushes into a full queue while pulsing `ovr_clr` in the same cycle. It then requires `rx_ovr` to still be set, and to drop only after a later, lone clear.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

   localparam int unsigned DATA_W  = 8;
   localparam int unsigned ERR_W   = 4;
   localparam int unsigned RXENT_W = DATA_W + ERR_W;
   localparam int unsigned LVL_W   = 3;

   typedef enum logic [LVL_W-1:0] {
      LVL_EIGHTH    = 3'd0,
      LVL_QUARTER   = 3'd1,
      LVL_HALF      = 3'd2,
      LVL_3QUARTER  = 3'd3,
      LVL_7EIGHTH   = 3'd4
   } lvl_code_e;

   // Threshold in entries for a level code; reserved codes map to half.
   function automatic int unsigned lvl_threshold(input int unsigned depth,
                                                 input logic [LVL_W-1:0] code);
      case (code)
         LVL_EIGHTH:   return depth / 8;
         LVL_QUARTER:  return depth / 4;
         LVL_HALF:     return depth / 2;
         LVL_3QUARTER: return (3 * depth) / 4;
         LVL_7EIGHTH:  return (7 * depth) / 8;
         default:      return depth / 2;
      endcase
   endfunction

endpackage

// File: rtl/ufifo_queue.sv
module ufifo_queue #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             single,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full,
   output logic [CNT_W-1:0] count,
   output logic             push_ok
);

   generate
      if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ufifo_queue: DEPTH must be a power of two and at least 8");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("ufifo_queue: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] limit;
   logic             pop_ok;

   assign limit   = single ? CNT_W'(1) : CNT_W'(DEPTH);
   assign empty   = (count == '0);
   assign full    = (count == limit);
   assign pop_ok  = pop && !empty && !flush;
   assign push_ok = push && !flush && (!full || pop_ok);
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + PTR_W'(1);
         if (pop_ok)  rd_ptr <= rd_ptr + PTR_W'(1);
         case ({push_ok, pop_ok})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

endmodule

// File: rtl/ufifo_level.sv
module ufifo_level #(
   parameter int unsigned DEPTH  = 16,
   parameter bit          IS_RX  = 1'b1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             load,
   input  logic [uart_fifo_pkg::LVL_W-1:0]  sel,
   input  logic                             single,
   input  logic [CNT_W-1:0]                 count,
   output logic                             irq
);
   import uart_fifo_pkg::*;

   logic [LVL_W-1:0] code_q;
   logic [CNT_W-1:0] thresh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    code_q <= LVL_HALF;
      else if (load) code_q <= sel;
   end

   assign thresh = CNT_W'(lvl_threshold(DEPTH, code_q));

   generate
      if (IS_RX) begin : g_rx
         assign irq = single ? (count != '0) : (count >= thresh);
      end else begin : g_tx
         assign irq = single ? (count == '0) : (count <= thresh);
      end
   endgenerate

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair #(
   parameter int unsigned DEPTH = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        fifo_en,
   input  logic        lvl_load,
   input  logic [2:0]  tx_lvl_sel,
   input  logic [2:0]  rx_lvl_sel,
   input  logic        tx_wr,
   input  logic [7:0]  tx_wdata,
   input  logic        tx_rd,
   output logic [7:0]  tx_rdata,
   output logic        tx_empty,
   output logic        tx_full,
   output logic        tx_irq,
   input  logic        rx_wr,
   input  logic [7:0]  rx_wdata,
   input  logic [3:0]  rx_werr,
   input  logic        rx_rd,
   output logic [11:0] rx_rdata,
   output logic        rx_empty,
   output logic        rx_full,
   output logic        rx_irq,
   input  logic        ovr_clr,
   output logic        rx_ovr
);
   import uart_fifo_pkg::*;

   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   logic             en_q, flush, single;
   logic [CNT_W-1:0] tx_cnt, rx_cnt;
   logic             tx_push_ok, rx_push_ok, rx_drop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= fifo_en;
   end

   assign flush  = (fifo_en != en_q);
   assign single = !en_q;

   ufifo_queue #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(flush), .single(single),
      .push(tx_wr), .wdata(tx_wdata), .pop(tx_rd), .rdata(tx_rdata),
      .empty(tx_empty), .full(tx_full), .count(tx_cnt), .push_ok(tx_push_ok)
   );

   ufifo_queue #(.WIDTH(RXENT_W), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(flush), .single(single),
      .push(rx_wr), .wdata({rx_werr, rx_wdata}), .pop(rx_rd), .rdata(rx_rdata),
      .empty(rx_empty), .full(rx_full), .count(rx_cnt), .push_ok(rx_push_ok)
   );

   ufifo_level #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_txlvl (
      .clk(clk), .rst_n(rst_n), .load(lvl_load), .sel(tx_lvl_sel),
      .single(single), .count(tx_cnt), .irq(tx_irq)
   );

   ufifo_level #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rxlvl (
      .clk(clk), .rst_n(rst_n), .load(lvl_load), .sel(rx_lvl_sel),
      .single(single), .count(rx_cnt), .irq(rx_irq)
   );

   // A byte lost at a full receive queue; a mode-change cycle drops silently.
   assign rx_drop = rx_wr && !rx_push_ok && !flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rx_ovr <= 1'b0;
      else if (rx_drop) rx_ovr <= 1'b1;
      else if (ovr_clr) rx_ovr <= 1'b0;
   end

endmodule

// File: rtl/uart_fifo_pair_chk.sv
module uart_fifo_pair_chk (
   input logic clk,
   input logic rst_n,
   input logic fifo_en,
   input logic ovr_clr,
   input logic tx_wr,
   input logic tx_rd,
   input logic tx_empty,
   input logic tx_full,
   input logic tx_irq,
   input logic rx_wr,
   input logic rx_rd,
   input logic rx_empty,
   input logic rx_full,
   input logic rx_irq,
   input logic rx_ovr
);

   p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_empty && tx_full) && !(rx_empty && rx_full));

   p_hold_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && $stable(fifo_en)) |-> (rx_full == !rx_empty) && (tx_full == !tx_empty));

   p_rx_irq_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_empty |-> !rx_irq);

   p_tx_irq_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> tx_irq);

   p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && rx_wr && !rx_rd && $stable(fifo_en)) |=> rx_ovr);

   p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ovr && !ovr_clr) |=> rx_ovr);

   p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fifo_en) |=> (tx_empty && rx_empty));

   p_full_swap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && rx_wr && rx_rd && $stable(fifo_en)) |=> rx_full);

   p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty && tx_rd && !tx_wr) |=> tx_empty);

endmodule

bind uart_fifo_pair uart_fifo_pair_chk u_chk (.*);

// File: tb/uart_fifo_pair_bench.sv
`timescale 1ns/1ps
module uart_fifo_pair_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fifo_en = 1'b0, lvl_load = 1'b0;
   logic [2:0]  tx_lvl_sel = '0, rx_lvl_sel = '0;
   logic        tx_wr = 1'b0, tx_rd = 1'b0, rx_wr = 1'b0, rx_rd = 1'b0, ovr_clr = 1'b0;
   logic [7:0]  tx_wdata = '0, rx_wdata = '0;
   logic [3:0]  rx_werr = '0;
   logic [7:0]  tx_rdata;
   logic [11:0] rx_rdata;
   logic        tx_empty, tx_full, tx_irq, rx_empty, rx_full, rx_irq, rx_ovr;

   int tests = 0, fails = 0;
   bit done = 1'b0;
   logic [7:0]  tx_q[$];
   logic [11:0] rx_q[$];

   always #4 clk = ~clk;

   uart_fifo_pair u_uart_fifo_pair (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic idle();
      tx_wr = 0; tx_rd = 0; rx_wr = 0; rx_rd = 0; ovr_clr = 0; lvl_load = 0;
   endtask

   task automatic tx_push(input logic [7:0] d, input bit accept);
      step(); tx_wr = 1; tx_wdata = d;
      if (accept) tx_q.push_back(d);
      step(); idle();
   endtask

   task automatic rx_push(input logic [7:0] d, input logic [3:0] e, input bit accept, input bit clr);
      step(); rx_wr = 1; rx_wdata = d; rx_werr = e; ovr_clr = clr;
      if (accept) rx_q.push_back({e, d});
      step(); idle();
   endtask

   task automatic tx_pop();
      step(); tx_rd = 1; step(); idle();
   endtask

   task automatic rx_pop();
      step(); rx_rd = 1; step(); idle();
   endtask

   task automatic load_lvl(input logic [2:0] t, input logic [2:0] r);
      step(); lvl_load = 1; tx_lvl_sel = t; rx_lvl_sel = r; step(); idle();
   endtask

   task automatic set_mode(input logic m);
      step(); fifo_en = m; tx_q.delete(); rx_q.delete(); step(); step();
   endtask

   // Monitor: every accepted pop is compared with the scoreboard head.
   always @(negedge clk) begin
      if (rst_n && tx_rd && !tx_empty) begin
         if (tx_q.size() == 0) chk("R3 tx pop with empty scoreboard", 1, 0);
         else chk("R3 tx order", tx_rdata, tx_q.pop_front());
      end
      if (rst_n && rx_rd && !rx_empty) begin
         if (rx_q.size() == 0) chk("R4 rx pop with empty scoreboard", 1, 0);
         else chk("R4 rx entry", rx_rdata, rx_q.pop_front());
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) step();
      rst_n = 1; step();
      // R1 reset state
      chk("R1 tx_empty", tx_empty, 1); chk("R1 rx_empty", rx_empty, 1);
      chk("R1 tx_full", tx_full, 0);   chk("R1 rx_full", rx_full, 0);
      chk("R1 tx_irq", tx_irq, 1);     chk("R1 rx_irq", rx_irq, 0);
      chk("R1 rx_ovr", rx_ovr, 0);

      // R2 holding mode
      tx_push(8'hA5, 1);
      chk("R2 tx_full after one", tx_full, 1); chk("R7 hold tx_irq", tx_irq, 0);
      tx_push(8'h3C, 0);
      tx_pop();
      chk("R2 tx_empty after pop", tx_empty, 1); chk("R7 hold tx_irq empty", tx_irq, 1);
      rx_push(8'h11, 4'h2, 1, 0);
      chk("R2 rx_full", rx_full, 1); chk("R6 hold rx_irq", rx_irq, 1);
      rx_push(8'h22, 4'h0, 0, 0);
      chk("R8 hold overrun", rx_ovr, 1);
      rx_pop();
      chk("R8 ovr sticky after read", rx_ovr, 1);
      step(); ovr_clr = 1; step(); idle();
      chk("R8 ovr cleared", rx_ovr, 0);

      // R9 flush on enable
      tx_push(8'h77, 1);
      set_mode(1);
      chk("R9 tx flushed", tx_empty, 1); chk("R9 tx not full", tx_full, 0);

      // R3/R6 FIFO mode, reset level half (8)
      for (int i = 0; i < 7; i++) rx_push(8'(i), 4'(i), 1, 0);
      chk("R6 rx_irq at 7", rx_irq, 0);
      rx_push(8'h07, 4'h7, 1, 0);
      chk("R6 rx_irq at 8 (R1 level half)", rx_irq, 1);
      for (int i = 8; i < 15; i++) rx_push(8'(8'h40 + i), 4'(i), 1, 0);
      chk("R3 rx not full at 15", rx_full, 0);
      rx_push(8'h4F, 4'hF, 1, 0);
      chk("R3 rx full at 16", rx_full, 1);
      rx_push(8'hEE, 4'h1, 0, 0);
      chk("R8 fifo overrun", rx_ovr, 1);
      rx_push(8'hED, 4'h1, 0, 1);
      chk("R8 set wins over clear", rx_ovr, 1);
      step(); ovr_clr = 1; step(); idle();
      chk("R8 lone clear", rx_ovr, 0);
      // R10 simultaneous push and pop at full
      step(); rx_wr = 1; rx_wdata = 8'h99; rx_werr = 4'hA; rx_rd = 1;
      rx_q.push_back({4'hA, 8'h99});
      step(); idle();
      chk("R10 still full", rx_full, 1); chk("R10 no overrun", rx_ovr, 0);
      for (int i = 0; i < 16; i++) rx_pop();
      chk("R3 rx drained", rx_empty, 1);
      chk("R3 scoreboard drained", 32'(rx_q.size()), 0);

      // R5 levels: rx 1/4 (4), tx 1/8 (2)
      load_lvl(3'd0, 3'd1);
      for (int i = 0; i < 3; i++) rx_push(8'(i + 1), 4'h3, 1, 0);
      chk("R5 rx quarter at 3", rx_irq, 0);
      rx_push(8'h04, 4'h3, 1, 0);
      chk("R5 rx quarter at 4", rx_irq, 1);
      for (int i = 0; i < 4; i++) rx_pop();
      tx_push(8'h01, 1); tx_push(8'h02, 1);
      chk("R7 tx eighth at 2", tx_irq, 1);
      tx_push(8'h03, 1);
      chk("R7 tx eighth at 3", tx_irq, 0);
      for (int i = 0; i < 3; i++) tx_pop();
      // reserved code 6 -> half; tx code 4 -> 14
      load_lvl(3'd4, 3'd6);
      for (int i = 0; i < 7; i++) rx_push(8'(i), 4'h5, 1, 0);
      chk("R5 rx reserved at 7", rx_irq, 0);
      rx_push(8'h07, 4'h5, 1, 0);
      chk("R5 rx reserved at 8", rx_irq, 1);
      for (int i = 0; i < 8; i++) rx_pop();
      for (int i = 0; i < 14; i++) tx_push(8'(8'h80 + i), 1);
      chk("R7 tx 7/8 at 14", tx_irq, 1);
      tx_push(8'h8E, 1);
      chk("R7 tx 7/8 at 15", tx_irq, 0);
      tx_push(8'h8F, 1);
      chk("R3 tx full at 16", tx_full, 1);
      tx_push(8'hFF, 0);
      for (int i = 0; i < 16; i++) tx_pop();
      chk("R3 tx drained", tx_empty, 1);

      // R11 read of empty
      tx_pop();
      chk("R11 still empty", tx_empty, 1);
      tx_push(8'h5A, 1);
      chk("R11 one entry", tx_empty, 0);
      tx_pop();
      chk("R11 empty again", tx_empty, 1);

      // R9 flush back to holding mode
      rx_push(8'h33, 4'h0, 1, 0); rx_push(8'h34, 4'h0, 1, 0);
      set_mode(0);
      chk("R9 rx flushed", rx_empty, 1); chk("R9 rx irq", rx_irq, 0);

      repeat (3) step();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule